// File: doc/BRIEF.md
# Flash Erase/Program Suspend Controller

This block keeps the suspend and resume state of a serial NOR flash device model. An upstream decoder hands it one 8-bit opcode per completed chip-select frame, and the operation engine tells it when an embedded erase or program starts, of which kind and for how many clock cycles. The block owns the countdown of that operation. It drives the BUSY and SUS status bits, and it gives one accept or reject strobe for every opcode. It also raises a pause line that tells the engine to freeze while an operation is being suspended or is parked.

A suspend is honoured only for a sector erase, a block erase, a page program or a quad page program that is running. It must also fall outside a guard window that opens on each resume. Once the suspend latency has passed, BUSY falls and SUS rises. The block remembers whether an erase or a program was parked, and it rejects a different set of opcodes in each case. A resume puts the operation back to work with the cycles it had left. An asynchronous power-on reset abandons any parked operation.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `busy`, `sus`, `pause`, `opAccept` and `opReject` are all 0.
- R2: A start (`startValid` high, `startType` not 0, `startLen` not 0) sampled in idle at edge S makes `busy` 1 from S until edge S+`startLen`, after which `busy` is 0. A start sampled while `busy` or `sus` is 1 is ignored. Kind codes: 1 sector erase, 2 block erase, 3 chip erase, 4 page program, 5 quad page program, 6 other.
- R3: Opcode 75h is accepted when an operation of kind 1, 2, 4 or 5 is running and not in its final cycle. `opAccept` is 1 and `pause` is 1 in the cycle after the opcode's edge.
- R4: Opcode 75h is rejected, with no change to `busy`, `sus` or `pause`, when the operation is idle, or is of kind 3 or 6, or when `sus` is 1.
- R5: For a suspend accepted at edge E, `busy` stays 1 and `sus` stays 0 until edge E+T_SUS. After that edge `busy` is 0 and `sus` is 1. In between, every opcode except 05h is rejected.
- R6: While an erase (kind 1 or 2) is suspended, opcodes 01h, 20h, 52h, D8h, C7h, 60h, 44h and 75h are rejected, and other opcodes such as 02h, 32h, 42h, 03h and 05h are accepted.
- R7: While a program (kind 4 or 5) is suspended, opcodes 01h, 02h, 32h, 42h and 75h are rejected, and erase opcodes, 03h and 05h are accepted.
- R8: While the operation is suspended its countdown is frozen. Opcode 7Ah is accepted, and in the next cycle `sus` is 0, `busy` is 1 and `pause` is 0. The operation then ends after exactly as many running cycles as it had left.
- R9: Opcode 7Ah is rejected when `sus` is 0.
- R10: After a resume sampled at edge R, a 75h sampled at edge R+k is rejected for k ≤ T_GAP and may be accepted for k = T_GAP+1.
- R11: A 75h sampled on the edge that ends the operation is rejected, and `busy` falls on that edge. One edge earlier, the same 75h is accepted.
- R12: Every sampled opcode yields exactly one one-cycle strobe, `opAccept` or `opReject`, in the next cycle. In idle every opcode other than 75h and 7Ah is accepted. While running, everything except 05h and a qualifying 75h is rejected. 05h is accepted in every state.
- R13: A power-on reset while suspended clears `sus`, `busy` and `pause` and abandons the parked operation, so a later 7Ah is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| opValid | input | 1 | One-cycle strobe: a decoded opcode is present |
| opCode | input | 8 | Decoded instruction opcode |
| startValid | input | 1 | One-cycle strobe: the engine starts an embedded operation |
| startType | input | 3 | Kind of the operation being started (codes in R2) |
| startLen | input | CNT_W | Length of the operation in running cycles |
| busy | output | 1 | BUSY status bit |
| sus | output | 1 | SUS status bit |
| pause | output | 1 | Freeze request to the operation engine |
| opAccept | output | 1 | Opcode accepted, one cycle after it is sampled |
| opReject | output | 1 | Opcode ignored, one cycle after it is sampled |

## Verification
Two functions can land on the same clock edge: a suspend request and the natural end of the operation's countdown. The bench times a 75h to arrive exactly on the edge where the remaining count is one, and checks that completion wins: a reject strobe appears, BUSY falls and SUS stays 0. In a second run it sends the same opcode one edge earlier and checks that it is accepted and that, after the resume, one running cycle is left. The guard window is probed the same way, with a 75h on the last forbidden edge and another on the first allowed edge.

// File: rtl/flash_sus_pkg.sv
package flash_sus_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_SECT_ERASE  = 3'd1,
    OP_BLOCK_ERASE = 3'd2,
    OP_CHIP_ERASE  = 3'd3,
    OP_PAGE_PROG   = 3'd4,
    OP_QUAD_PROG   = 3'd5,
    OP_OTHER       = 3'd6
  } opKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_SUSP
  } susState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRemain;
    logic runTick;
    logic loadLat;
    logic latTick;
    logic loadGuard;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic remainLast;
    logic latLast;
    logic guardClear;
    logic lenValid;
  } dpStat_t;

  localparam logic [7:0] OPC_SUSPEND   = 8'h75;
  localparam logic [7:0] OPC_RESUME    = 8'h7A;
  localparam logic [7:0] OPC_STATUS_RD = 8'h05;

  function automatic logic canSuspend(opKind_t k);
    return (k == OP_SECT_ERASE) || (k == OP_BLOCK_ERASE) ||
           (k == OP_PAGE_PROG)  || (k == OP_QUAD_PROG);
  endfunction

  function automatic logic isEraseKind(opKind_t k);
    return (k == OP_SECT_ERASE) || (k == OP_BLOCK_ERASE);
  endfunction

  // opcodes refused while an operation is parked
  function automatic logic isBarred(logic [7:0] code, logic eraseParked);
    logic barred;
    case (code)
      8'h01, OPC_SUSPEND:                       barred = 1'b1;
      8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44: barred = eraseParked;
      8'h02, 8'h32, 8'h42:                      barred = !eraseParked;
      default:                                  barred = 1'b0;
    endcase
    return barred;
  endfunction

endpackage

// File: rtl/sus_datapath.sv
module sus_datapath
  import flash_sus_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int T_SUS = 4,
  parameter int T_GAP = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] startLen,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat
);

  localparam int LAT_W = $clog2(T_SUS + 1);
  localparam int GAP_W = $clog2(T_GAP + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(T_SUS);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(T_GAP);

  logic [CNT_W-1:0] remainQ;
  logic [LAT_W-1:0] latQ;
  logic [GAP_W-1:0] guardQ;

  // operation countdown, frozen whenever control does not tick it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remainQ <= '0;
    end else if (ctrl.loadRemain) begin
      remainQ <= startLen;
    end else if (ctrl.runTick) begin
      remainQ <= remainQ - 1'b1;
    end
  end

  // suspend latency counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
    end else if (ctrl.loadLat) begin
      latQ <= LAT_LOAD;
    end else if (ctrl.latTick && latQ != '0) begin
      latQ <= latQ - 1'b1;
    end
  end

  // resume-to-suspend guard window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardQ <= '0;
    end else if (ctrl.loadGuard) begin
      guardQ <= GAP_LOAD;
    end else if (guardQ != '0) begin
      guardQ <= guardQ - 1'b1;
    end
  end

  always_comb begin
    stat.remainLast = (remainQ == CNT_W'(1));
    stat.latLast    = (latQ == LAT_W'(1));
    stat.guardClear = (guardQ == '0);
    stat.lenValid   = (startLen != '0);
  end

  // R5: control only counts latency down after a load
  a_r5_latency_loaded: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.latTick |-> latQ != '0);

  // R8: countdown never moves without a tick or load
  a_r8_remain_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadRemain && !ctrl.runTick) |=> $stable(remainQ));

endmodule

// File: rtl/sus_ctrl.sv
module sus_ctrl
  import flash_sus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  input  logic       startValid,
  input  opKind_t    startType,
  input  dpStat_t    dpStat,
  output dpCtrl_t    dpCtrl,
  output logic       busy,
  output logic       sus,
  output logic       pause,
  output logic       opAccept,
  output logic       opReject
);

  susState_t stateQ;
  opKind_t   typeQ;
  logic      eraseParkedQ;
  logic      acceptQ;
  logic      rejectQ;

  logic suspendOk;
  logic suspendTake;
  logic resumeTake;
  logic startTake;
  logic opOk;

  always_comb begin
    suspendOk   = (stateQ == ST_RUN) && canSuspend(typeQ) &&
                  dpStat.guardClear && !dpStat.remainLast;
    suspendTake = opValid && (opCode == OPC_SUSPEND) && suspendOk;
    resumeTake  = opValid && (opCode == OPC_RESUME) && (stateQ == ST_SUSP);
    startTake   = startValid && (stateQ == ST_IDLE) &&
                  (startType != OP_NONE) && dpStat.lenValid;
  end

  // accept/reject decision for the opcode of this cycle
  always_comb begin
    if (opCode == OPC_STATUS_RD) begin
      opOk = 1'b1;
    end else if (opCode == OPC_SUSPEND) begin
      opOk = suspendOk;
    end else if (opCode == OPC_RESUME) begin
      opOk = (stateQ == ST_SUSP);
    end else begin
      case (stateQ)
        ST_IDLE: opOk = 1'b1;
        ST_SUSP: opOk = !isBarred(opCode, eraseParkedQ);
        default: opOk = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      typeQ        <= OP_NONE;
      eraseParkedQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (startTake) begin
            stateQ <= ST_RUN;
            typeQ  <= startType;
          end
        end
        ST_RUN: begin
          if (dpStat.remainLast) begin
            stateQ <= ST_IDLE;
            typeQ  <= OP_NONE;
          end else if (suspendTake) begin
            stateQ       <= ST_HOLD;
            eraseParkedQ <= isEraseKind(typeQ);
          end
        end
        ST_HOLD: begin
          if (dpStat.latLast) stateQ <= ST_SUSP;
        end
        ST_SUSP: begin
          if (resumeTake) stateQ <= ST_RUN;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptQ <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      acceptQ <= opValid && opOk;
      rejectQ <= opValid && !opOk;
    end
  end

  always_comb begin
    dpCtrl.loadRemain = startTake;
    dpCtrl.runTick    = (stateQ == ST_RUN);
    dpCtrl.loadLat    = suspendTake;
    dpCtrl.latTick    = (stateQ == ST_HOLD);
    dpCtrl.loadGuard  = resumeTake;
  end

  assign busy     = (stateQ == ST_RUN) || (stateQ == ST_HOLD);
  assign sus      = (stateQ == ST_SUSP);
  assign pause    = (stateQ == ST_HOLD) || (stateQ == ST_SUSP);
  assign opAccept = acceptQ;
  assign opReject = rejectQ;

  // R12: one strobe per sampled opcode
  a_r12_one_response: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (acceptQ ^ rejectQ));

  // R5: SUS can only appear after the latency phase
  a_r5_sus_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateQ == ST_SUSP) |-> $past(stateQ) == ST_HOLD);

  // R8: parked operation stays parked until a resume
  a_r8_parked_until_resume: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SUSP && !(opValid && opCode == OPC_RESUME)) |=> stateQ == ST_SUSP);

  // R6: an erase opcode is refused during erase suspend
  a_r6_erase_barred: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SUSP && eraseParkedQ && opValid && opCode == 8'hD8) |=> rejectQ);

  // R7: a program opcode is refused during program suspend
  a_r7_prog_barred: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SUSP && !eraseParkedQ && opValid && opCode == 8'h02) |=> rejectQ);

  // R4: chip erase cannot be suspended
  a_r4_chip_erase_runs: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OPC_SUSPEND && typeQ == OP_CHIP_ERASE) |=> rejectQ);

  // R11: completion wins over a suspend on the same edge
  a_r11_finish_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && dpStat.remainLast && opValid && opCode == OPC_SUSPEND)
      |=> (rejectQ && stateQ == ST_IDLE));

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
  import flash_sus_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int T_SUS = 4,
  parameter int T_GAP = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [7:0]       opCode,
  input  logic             startValid,
  input  logic [2:0]       startType,
  input  logic [CNT_W-1:0] startLen,
  output logic             busy,
  output logic             sus,
  output logic             pause,
  output logic             opAccept,
  output logic             opReject
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  sus_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .startValid(startValid),
    .startType (opKind_t'(startType)),
    .dpStat    (dpStat),
    .dpCtrl    (dpCtrl),
    .busy      (busy),
    .sus       (sus),
    .pause     (pause),
    .opAccept  (opAccept),
    .opReject  (opReject)
  );

  sus_datapath #(
    .CNT_W(CNT_W),
    .T_SUS(T_SUS),
    .T_GAP(T_GAP)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .startLen(startLen),
    .ctrl    (dpCtrl),
    .stat    (dpStat)
  );

  // R1/R5: BUSY and SUS never both high
  a_r5_busy_sus_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && sus));

endmodule

// File: tb/test_flash_suspend_ctrl.sv
`timescale 1ns/1ps
module test_flash_suspend_ctrl;

  localparam int CNT_W = 16;
  localparam int T_SUS = 4;
  localparam int T_GAP = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             opValid = 1'b0;
  logic [7:0]       opCode = '0;
  logic             startValid = 1'b0;
  logic [2:0]       startType = '0;
  logic [CNT_W-1:0] startLen = '0;
  logic busy, sus, pause, opAccept, opReject;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  flash_suspend_ctrl #(.CNT_W(CNT_W), .T_SUS(T_SUS), .T_GAP(T_GAP)) i_flash_suspend_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .startValid(startValid), .startType(startType), .startLen(startLen),
    .busy(busy), .sus(sus), .pause(pause), .opAccept(opAccept), .opReject(opReject)
  );

  // {opcode, accepted during erase suspend, accepted during program suspend}
  localparam int NVEC = 13;
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h20, 2'b01}, {8'h01, 2'b00}, {8'h42, 2'b10}, {8'h52, 2'b01},
    {8'h03, 2'b11}, {8'hD8, 2'b01}, {8'h02, 2'b10}, {8'hC7, 2'b01},
    {8'h75, 2'b00}, {8'h60, 2'b01}, {8'h32, 2'b10}, {8'h44, 2'b01},
    {8'h05, 2'b11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called at a negedge; sampled on the next posedge; returns at the following negedge
  task automatic sendOp(input logic [7:0] code);
    opValid = 1'b1;
    opCode  = code;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic startOp(input logic [2:0] kind, input int len);
    startValid = 1'b1;
    startType  = kind;
    startLen   = CNT_W'(len);
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic powerReset();
    rstN = 1'b0;
    waitN(2);
    rstN = 1'b1;
  endtask

  task automatic walkTable(input bit eraseCol, input string req);
    for (int i = 0; i < NVEC; i++) begin
      logic expOk;
      sendOp(VEC[i][9:2]);
      expOk = eraseCol ? VEC[i][1] : VEC[i][0];
      check({req, $sformatf(" opcode %0h accept", VEC[i][9:2])}, opAccept, expOk);
      check({req, $sformatf(" opcode %0h reject", VEC[i][9:2])}, opReject, !expOk);
    end
    check({req, " still suspended"}, sus, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitN(2);
    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 sus", sus, 0);
    check("R1 pause/strobes", {pause, opAccept, opReject}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first cycle after reset", {busy, sus, pause, opAccept, opReject}, 0);

    // R12/R4/R9: idle responses
    sendOp(8'h03);
    check("R12 idle read accepted", {opAccept, opReject}, 2'b10);
    sendOp(8'h75);
    check("R4 suspend when idle rejected", {opAccept, opReject}, 2'b01);
    sendOp(8'h7A);
    check("R9 resume when idle rejected", {opAccept, opReject}, 2'b01);

    // R2: plain run; a second start is ignored; R12 opcodes while running
    startOp(3'd1, 5);                 // edge S
    startOp(3'd4, 100);               // S+1, ignored
    check("R2 busy after start", busy, 1);
    waitN(2);                         // S+3.5
    sendOp(8'h03);                    // sampled S+4
    check("R12 read while running rejected", {opAccept, opReject}, 2'b01);
    check("R2 busy in last cycle", busy, 1);
    waitN(1);                         // S+5.5
    check("R2 busy drops after length", busy, 0);
    sendOp(8'h05);
    check("R2 second start ignored / R12 status in idle", {busy, opAccept}, 2'b01);

    // R3/R5/R6/R8: block erase suspended, walked and resumed
    startOp(3'd2, 20);                // S
    waitN(4);
    sendOp(8'h75);                    // E = S+5, remain 15 left
    check("R3 suspend accepted", {opAccept, opReject}, 2'b10);
    check("R3 pause raised", pause, 1);
    check("R5 still busy in latency", {busy, sus}, 2'b10);
    sendOp(8'h05);                    // E+1
    check("R12 status read in latency", opAccept, 1);
    sendOp(8'h03);                    // E+2
    check("R5 read in latency rejected", opReject, 1);
    waitN(1);                         // E+3.5
    check("R5 sus not yet", {busy, sus}, 2'b10);
    waitN(1);                         // E+4.5
    check("R5 sus after latency", {busy, sus, pause}, 3'b011);
    walkTable(1'b1, "R6");
    sendOp(8'h7A);                    // R
    check("R8 resume accepted", opAccept, 1);
    check("R8 running again", {busy, sus, pause}, 3'b100);
    waitN(14);                        // R+14.5
    check("R8 busy before remaining count ends", busy, 1);
    waitN(1);                         // R+15.5
    check("R8 finishes after remaining count", busy, 0);

    // R7/R13: quad program suspended, then power loss
    startOp(3'd5, 60);
    sendOp(8'h75);
    check("R3 quad program suspend accepted", opAccept, 1);
    waitN(T_SUS);
    check("R7 suspended", sus, 1);
    walkTable(1'b0, "R7");
    powerReset();
    check("R13 reset clears state", {busy, sus, pause}, 0);
    sendOp(8'h7A);
    check("R13 parked operation abandoned", {opAccept, opReject, busy}, 3'b010);

    // R4: chip erase and other kinds cannot be suspended
    startOp(3'd3, 30);                // S
    sendOp(8'h75);                    // S+1
    check("R4 chip erase suspend rejected", {opAccept, opReject}, 2'b01);
    check("R4 chip erase keeps running", {busy, sus, pause}, 3'b100);
    waitN(29);                        // S+30.5
    check("R2 chip erase ends on length", busy, 0);
    startOp(3'd6, 10);
    sendOp(8'h75);
    check("R4 other kind suspend rejected", {opReject, busy, pause}, 3'b110);
    waitN(9);

    // R10: guard window after resume
    startOp(3'd1, 100);
    sendOp(8'h75);
    waitN(T_SUS);
    check("R10 first suspend", sus, 1);
    sendOp(8'h7A);                    // R
    waitN(T_GAP - 1);
    sendOp(8'h75);                    // R+T_GAP
    check("R10 suspend inside guard rejected", {opAccept, opReject, pause}, 3'b010);
    sendOp(8'h75);                    // R+T_GAP+1
    check("R10 suspend after guard accepted", {opAccept, pause}, 2'b11);
    powerReset();

    // R11: suspend on the finishing edge
    startOp(3'd4, 8);                 // S
    waitN(7);
    sendOp(8'h75);                    // S+8, remaining 1
    check("R11 suspend on final edge rejected", {opAccept, opReject}, 2'b01);
    check("R11 completion wins", {busy, sus, pause}, 0);
    startOp(3'd4, 8);                 // S
    waitN(6);
    sendOp(8'h75);                    // S+7, remaining 2
    check("R11 suspend one edge earlier accepted", opAccept, 1);
    waitN(T_SUS);
    sendOp(8'h7A);                    // R
    check("R11 one cycle left after resume", busy, 1);
    waitN(1);
    check("R11 ends after last cycle", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule